// File: doc/BRIEF.md
# Lane Fetch Command Manager

This block is the front end of one lane in a decoupled multi-lane vector-thread unit. It takes two kinds of fetch request. The first is a vector-fetch, which the control processor broadcasts and which the block queues in arrival order. The second is a thread-fetch, which a virtual processor (VP) mapped to the lane posts for itself and which waits in a slot owned by that VP. Each cycle the block picks one request, compares its block address with a direct-mapped tag array for the lane's instruction-block cache, and turns it into an execute directive. The directive names the cache entry that holds the block, and it applies either to every VP in the lane or to the one VP that asked for it.

On a miss the block raises a refill request and holds it until the fill completes. Only one refill is outstanding at a time. While it is outstanding, later requests that hit a different entry still produce directives. Directives wait in an internal output queue for the execution side. A cache entry is not chosen for replacement while a queued directive still points at it. The cache data array, the refill memory and the execution cluster sit outside the block, behind valid/ready or request/done ports.

Top module: `lane_fetch_mgr`

## Requirements
- R1: `cmd_ready` is low exactly when the command queue holds `CQ_DEPTH` vector-fetch commands (default 4). Vector-fetch commands are processed in the order they were accepted.
- R2: Each VP owns one thread-fetch slot. `tf_ready` is low while the slot of the VP given on `tf_vp` is still pending.
- R3: A request whose block address hits produces a directive with `dir_idx` equal to the low log2(`NENT`) bits of that address (bits [2:0] by default), and it raises no refill request.
- R4: A miss raises `refill_req`, with `refill_addr` equal to the fetch address, and holds it until `refill_done`. `refill_req` is low in the cycle after `refill_done`. The directive for the missed request follows, and a later request for the same address hits. After reset every entry is invalid.
- R5: A vector-fetch directive has `dir_all` = 1 and `dir_vp` = 0. A thread-fetch directive has `dir_all` = 0 and `dir_vp` equal to the requesting VP.
- R6: When a vector-fetch command and at least one thread-fetch are both waiting, the block serves the kind that was not served last. After reset, a thread-fetch is served first only if the last kind served was a vector-fetch.
- R7: Pending thread-fetch slots are scanned starting from the VP after the one most recently served, wrapping around. After reset the scan starts at VP 0.
- R8: At most one refill is outstanding, and `refill_addr` is stable while it is. A request that hits a different entry during the refill produces its directive before the refill completes. A request that misses waits for the refill to finish.
- R9: A miss to an entry that some queued directive still references raises no refill until all such directives have left the output queue.
- R10: No more than `DQ_DEPTH` directives are held. While `dir_ready` is low, `dir_valid` and the directive fields stay stable.
- R11: After reset, `cmd_ready` and `tf_ready` are high, and `dir_valid` and `refill_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Vector-fetch command offered |
| cmd_ready | output | 1 | Command queue can accept |
| cmd_addr | input | AW | Block address of the vector-fetch |
| tf_valid | input | 1 | Thread-fetch posted by a VP |
| tf_ready | output | 1 | Slot of `tf_vp` is free |
| tf_vp | input | VPW | Posting VP |
| tf_addr | input | AW | Block address of the thread-fetch |
| refill_req | output | 1 | Refill outstanding |
| refill_addr | output | AW | Block address being refilled |
| refill_done | input | 1 | One-cycle pulse: refill complete |
| dir_valid | output | 1 | Directive available |
| dir_ready | input | 1 | Execution side takes the directive |
| dir_all | output | 1 | Directive applies to all VPs |
| dir_vp | output | VPW | Target VP for a thread directive |
| dir_idx | output | IW | Cache entry holding the block |

## Verification
A wrong tag or valid bit shows up within a few cycles of the next lookup, either as a spurious or missing refill request or as a wrong `dir_idx`. A reference count that drifts shows up as a refill that starts too early, while an older directive for the same entry is still queued, or as a lane that stalls for good. A wrong arbitration flag or scan pointer shows up only later, as a change in directive order. The order of directives against a scoreboard is therefore the main observable, and each scenario is built so that this order is fully determined.

// File: rtl/lfm_pkg.sv
package lfm_pkg;

    typedef enum logic [1:0] {
        MS_IDLE = 2'd0,
        MS_WAIT = 2'd1,
        MS_EMIT = 2'd2
    } miss_e;

endpackage

// File: rtl/lfm_fifo.sv
module lfm_fifo #(
    parameter int W = 8,
    parameter int D = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_data,
    output logic         in_ready,
    input  logic         pop,
    output logic         out_valid,
    output logic [W-1:0] out_data
);
    localparam int PW = (D > 1) ? $clog2(D) : 1;
    localparam int CW = $clog2(D + 1);

    typedef struct packed {
        logic [D-1:0][W-1:0] mem;
        logic [PW-1:0]       wp;
        logic [PW-1:0]       rp;
        logic [CW-1:0]       cnt;
    } fifo_t;

    fifo_t f_q, f_d;

    assign in_ready  = (f_q.cnt != CW'(D));
    assign out_valid = (f_q.cnt != '0);
    assign out_data  = f_q.mem[f_q.rp];

    always_comb begin
        logic do_push;
        logic do_pop;
        f_d     = f_q;
        do_push = push && in_ready;
        do_pop  = pop && out_valid;
        if (do_push) begin
            f_d.mem[f_q.wp] = push_data;
            f_d.wp = (f_q.wp == PW'(D - 1)) ? '0 : f_q.wp + PW'(1);
        end
        if (do_pop) begin
            f_d.rp = (f_q.rp == PW'(D - 1)) ? '0 : f_q.rp + PW'(1);
        end
        if (do_push && !do_pop) begin
            f_d.cnt = f_q.cnt + CW'(1);
        end else if (do_pop && !do_push) begin
            f_d.cnt = f_q.cnt - CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            f_q <= '0;
        end else begin
            f_q <= f_d;
        end
    end

endmodule

// File: rtl/lfm_rr_pick.sv
module lfm_rr_pick #(
    parameter int N  = 4,
    parameter int SW = 2
) (
    input  logic [N-1:0]  req,
    input  logic [SW-1:0] start,
    output logic          any,
    output logic [SW-1:0] sel
);
    always_comb begin
        any = 1'b0;
        sel = '0;
        for (int k = N - 1; k >= 0; k--) begin
            int j;
            j = (int'(start) + k) % N;
            if (req[j]) begin
                any = 1'b1;
                sel = SW'(j);
            end
        end
    end

endmodule

// File: rtl/lane_fetch_mgr.sv
module lane_fetch_mgr #(
    parameter int AW       = 16,
    parameter int NVP      = 4,
    parameter int NENT     = 8,
    parameter int CQ_DEPTH = 4,
    parameter int DQ_DEPTH = 4,
    localparam int IW  = $clog2(NENT),
    localparam int VPW = (NVP > 1) ? $clog2(NVP) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cmd_valid,
    output logic           cmd_ready,
    input  logic [AW-1:0]  cmd_addr,
    input  logic           tf_valid,
    output logic           tf_ready,
    input  logic [VPW-1:0] tf_vp,
    input  logic [AW-1:0]  tf_addr,
    output logic           refill_req,
    output logic [AW-1:0]  refill_addr,
    input  logic           refill_done,
    output logic           dir_valid,
    input  logic           dir_ready,
    output logic           dir_all,
    output logic [VPW-1:0] dir_vp,
    output logic [IW-1:0]  dir_idx
);
    import lfm_pkg::*;

    localparam int TW = AW - IW;
    localparam int CW = $clog2(DQ_DEPTH + 1);
    localparam int DW = 1 + VPW + IW;

    typedef struct packed {
        logic [NVP-1:0]           pend;
        logic [NVP-1:0][AW-1:0]   tfa;
        logic [NENT-1:0][TW-1:0]  tag;
        logic [NENT-1:0]          vld;
        logic [NENT-1:0][CW-1:0]  rc;
        miss_e                    ms;
        logic [AW-1:0]            maddr;
        logic                     mall;
        logic [VPW-1:0]           mvp;
        logic                     pref_tf;
        logic [VPW-1:0]           ptr;
    } st_t;

    st_t s_q, s_d;

    // command queue
    logic          cq_pop;
    logic          cq_valid;
    logic [AW-1:0] cq_addr;

    lfm_fifo #(.W(AW), .D(CQ_DEPTH)) u_cq (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (cmd_valid),
        .push_data(cmd_addr),
        .in_ready (cmd_ready),
        .pop      (cq_pop),
        .out_valid(cq_valid),
        .out_data (cq_addr)
    );

    // directive queue
    logic          dq_push;
    logic [DW-1:0] dq_data;
    logic          dq_ready;
    logic [DW-1:0] dq_head;

    lfm_fifo #(.W(DW), .D(DQ_DEPTH)) u_dq (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (dq_push),
        .push_data(dq_data),
        .in_ready (dq_ready),
        .pop      (dir_ready),
        .out_valid(dir_valid),
        .out_data (dq_head)
    );

    assign {dir_all, dir_vp, dir_idx} = dq_head;

    // thread slot scan
    logic           tf_any;
    logic [VPW-1:0] tf_sel;

    lfm_rr_pick #(.N(NVP), .SW(VPW)) u_pick (
        .req  (s_q.pend),
        .start(s_q.ptr),
        .any  (tf_any),
        .sel  (tf_sel)
    );

    assign tf_ready    = !s_q.pend[tf_vp];
    assign refill_req  = (s_q.ms == MS_WAIT);
    assign refill_addr = s_q.maddr;

    logic           use_tf;
    logic           req_valid;
    logic [AW-1:0]  req_addr;
    logic [IW-1:0]  req_idx;
    logic           req_hit;
    logic [IW-1:0]  m_idx;
    logic           consume;
    logic           do_inc;
    logic [IW-1:0]  inc_idx;
    logic           do_dec;

    always_comb begin
        s_d       = s_q;
        dq_push   = 1'b0;
        dq_data   = '0;
        cq_pop    = 1'b0;
        consume   = 1'b0;
        do_inc    = 1'b0;
        inc_idx   = '0;

        use_tf    = tf_any && (!cq_valid || s_q.pref_tf);
        req_valid = tf_any || cq_valid;
        req_addr  = use_tf ? s_q.tfa[tf_sel] : cq_addr;
        req_idx   = req_addr[IW-1:0];
        req_hit   = s_q.vld[req_idx] && (s_q.tag[req_idx] == req_addr[AW-1:IW]);
        m_idx     = s_q.maddr[IW-1:0];
        do_dec    = dir_valid && dir_ready;

        // thread-fetch posting
        if (tf_valid && tf_ready) begin
            s_d.pend[tf_vp] = 1'b1;
            s_d.tfa[tf_vp]  = tf_addr;
        end

        // directive generation
        if (s_q.ms == MS_EMIT) begin
            if (dq_ready) begin
                dq_push  = 1'b1;
                dq_data  = {s_q.mall, s_q.mvp, m_idx};
                do_inc   = 1'b1;
                inc_idx  = m_idx;
                s_d.ms   = MS_IDLE;
            end
        end else if (req_valid) begin
            if (req_hit) begin
                if (dq_ready) begin
                    dq_push = 1'b1;
                    dq_data = {!use_tf, use_tf ? tf_sel : VPW'(0), req_idx};
                    do_inc  = 1'b1;
                    inc_idx = req_idx;
                    consume = 1'b1;
                end
            end else if (s_q.ms == MS_IDLE && s_q.rc[req_idx] == '0) begin
                s_d.ms           = MS_WAIT;
                s_d.maddr        = req_addr;
                s_d.mall         = !use_tf;
                s_d.mvp          = use_tf ? tf_sel : VPW'(0);
                s_d.vld[req_idx] = 1'b0;
                consume          = 1'b1;
            end
        end

        // refill completion
        if (refill_done && s_q.ms == MS_WAIT) begin
            s_d.tag[m_idx] = s_q.maddr[AW-1:IW];
            s_d.vld[m_idx] = 1'b1;
            s_d.ms         = MS_EMIT;
        end

        // request retirement and arbitration state
        if (consume) begin
            if (use_tf) begin
                s_d.pend[tf_sel] = 1'b0;
                s_d.ptr          = (tf_sel == VPW'(NVP - 1)) ? '0 : tf_sel + VPW'(1);
                s_d.pref_tf      = 1'b0;
            end else begin
                cq_pop      = 1'b1;
                s_d.pref_tf = 1'b1;
            end
        end

        // per-entry reference counts
        for (int e = 0; e < NENT; e++) begin
            logic up;
            logic dn;
            up = do_inc && (inc_idx == IW'(e));
            dn = do_dec && (dir_idx == IW'(e));
            if (up && !dn) begin
                s_d.rc[e] = s_q.rc[e] + CW'(1);
            end else if (dn && !up) begin
                s_d.rc[e] = s_q.rc[e] - CW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

endmodule

// File: rtl/lfm_checker.sv
module lfm_checker #(
    parameter int AW  = 16,
    parameter int VPW = 2,
    parameter int IW  = 3
) (
    input logic           clk,
    input logic           rst_n,
    input logic           tf_valid,
    input logic           tf_ready,
    input logic [VPW-1:0] tf_vp,
    input logic           refill_req,
    input logic [AW-1:0]  refill_addr,
    input logic           refill_done,
    input logic           dir_valid,
    input logic           dir_ready,
    input logic           dir_all,
    input logic [VPW-1:0] dir_vp,
    input logic [IW-1:0]  dir_idx
);
    a_r10_dir_hold: assert property (@(posedge clk) disable iff (!rst_n)
        dir_valid && !dir_ready |=> dir_valid && $stable({dir_all, dir_vp, dir_idx}));

    a_r8_refill_stable: assert property (@(posedge clk) disable iff (!rst_n)
        refill_req && !refill_done |=> refill_req && $stable(refill_addr));

    a_r4_fill_ends_req: assert property (@(posedge clk) disable iff (!rst_n)
        refill_req && refill_done |=> !refill_req);

    a_r2_slot_busy: assert property (@(posedge clk) disable iff (!rst_n)
        $past(tf_valid && tf_ready) && (tf_vp == $past(tf_vp)) |-> !tf_ready);

endmodule

bind lane_fetch_mgr lfm_checker #(.AW(AW), .VPW(VPW), .IW(IW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tf_valid   (tf_valid),
    .tf_ready   (tf_ready),
    .tf_vp      (tf_vp),
    .refill_req (refill_req),
    .refill_addr(refill_addr),
    .refill_done(refill_done),
    .dir_valid  (dir_valid),
    .dir_ready  (dir_ready),
    .dir_all    (dir_all),
    .dir_vp     (dir_vp),
    .dir_idx    (dir_idx)
);

// File: tb/lane_fetch_mgr_bench.sv
`timescale 1ns/1ps
module lane_fetch_mgr_bench;
    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0;
    logic          cmd_ready;
    logic [AW-1:0] cmd_addr = '0;
    logic          tf_valid = 1'b0;
    logic          tf_ready;
    logic [1:0]    tf_vp = '0;
    logic [AW-1:0] tf_addr = '0;
    logic          refill_req;
    logic [AW-1:0] refill_addr;
    logic          refill_done = 1'b0;
    logic          dir_valid;
    logic          dir_ready = 1'b1;
    logic          dir_all;
    logic [1:0]    dir_vp;
    logic [2:0]    dir_idx;

    always #2 clk = ~clk;

    lane_fetch_mgr u_lane_fetch_mgr (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_addr(cmd_addr),
        .tf_valid(tf_valid), .tf_ready(tf_ready), .tf_vp(tf_vp), .tf_addr(tf_addr),
        .refill_req(refill_req), .refill_addr(refill_addr), .refill_done(refill_done),
        .dir_valid(dir_valid), .dir_ready(dir_ready), .dir_all(dir_all),
        .dir_vp(dir_vp), .dir_idx(dir_idx)
    );

    int checks = 0;
    int fails  = 0;
    int fill_lat = 3;
    int refill_cnt = 0;
    logic [AW-1:0] refill_log[$];
    logic [5:0] exp_q[$];
    string      tag_q[$];
    bit finished = 1'b0;

    function automatic void chk(bit ok, string req, int act, int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endfunction

    function automatic void expect_dir(bit all, int vp, int idx, string req);
        exp_q.push_back({all, 2'(vp), 3'(idx)});
        tag_q.push_back(req);
    endfunction

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    // scoreboard monitor
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && dir_valid && dir_ready) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R5 unexpected directive", int'({dir_all, dir_vp, dir_idx}), 0);
                end else begin
                    logic [5:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    chk({dir_all, dir_vp, dir_idx} == e, t, int'({dir_all, dir_vp, dir_idx}), int'(e));
                end
            end
        end
    end

    // refill memory model
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && refill_req) begin
                refill_log.push_back(refill_addr);
                refill_cnt++;
                repeat (fill_lat) @(posedge clk);
                #1 refill_done = 1'b1;
                @(posedge clk);
                #1 refill_done = 1'b0;
            end
        end
    end

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    task automatic send_cmd(logic [AW-1:0] a);
        cmd_valid = 1'b1;
        cmd_addr  = a;
        forever begin
            @(negedge clk);
            if (cmd_ready) begin
                @(posedge clk);
                #1;
                break;
            end
        end
        cmd_valid = 1'b0;
    endtask

    task automatic post_tf(int vp, logic [AW-1:0] a);
        tf_valid = 1'b1;
        tf_vp    = 2'(vp);
        tf_addr  = a;
        forever begin
            @(negedge clk);
            if (tf_ready) begin
                @(posedge clk);
                #1;
                break;
            end
        end
        tf_valid = 1'b0;
    endtask

    task automatic idle(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic drain(string req);
        int w;
        w = 0;
        while (exp_q.size() != 0 && w < 500) begin
            @(posedge clk);
            w++;
        end
        #1;
        chk(exp_q.size() == 0, req, exp_q.size(), 0);
    endtask

    initial begin
        int base;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R11 reset state
        @(negedge clk);
        chk(cmd_ready == 1'b1, "R11 cmd_ready", int'(cmd_ready), 1);
        chk(tf_ready == 1'b1, "R11 tf_ready", int'(tf_ready), 1);
        chk(dir_valid == 1'b0, "R11 dir_valid", int'(dir_valid), 0);
        chk(refill_req == 1'b0, "R11 refill_req", int'(refill_req), 0);
        @(posedge clk); #1;

        // R4: first lookup misses and refills; R3: repeat hits
        expect_dir(1, 0, 3, "R4 miss directive");
        send_cmd(16'h0013);
        drain("R4 drain");
        chk(refill_cnt == 1, "R4 refill count", refill_cnt, 1);
        chk(refill_log[0] == 16'h0013, "R4 refill addr", int'(refill_log[0]), 16'h13);
        expect_dir(1, 0, 3, "R3 hit directive");
        send_cmd(16'h0013);
        drain("R3 drain");
        chk(refill_cnt == 1, "R3 no refill on hit", refill_cnt, 1);

        // R5 thread directive (vp2, idx5, miss then directive)
        expect_dir(0, 2, 5, "R5 thread directive vp2");
        post_tf(2, 16'h0025);
        drain("R5 drain");

        // R2 slot pending blocks tf_ready; R5 hit for vp1
        expect_dir(0, 1, 5, "R5 thread directive vp1");
        post_tf(1, 16'h0025);
        tf_vp = 2'd1;
        @(negedge clk);
        chk(tf_ready == 1'b0, "R2 slot pending", int'(tf_ready), 0);
        @(posedge clk); #1;
        drain("R2 drain");

        // R1 command queue full, order preserved; R10 stall
        dir_ready = 1'b0;
        for (int i = 0; i < 8; i++) begin
            send_cmd((i % 2 == 0) ? 16'h0013 : 16'h0025);
            expect_dir(1, 0, (i % 2 == 0) ? 3 : 5, "R1 order");
        end
        idle(3);
        @(negedge clk);
        chk(cmd_ready == 1'b0, "R1 cmd_ready low when full", int'(cmd_ready), 0);
        chk(dir_valid == 1'b1, "R10 dir_valid held", int'(dir_valid), 1);
        @(posedge clk); #1;
        dir_ready = 1'b1;
        drain("R1 drain");

        // R9 miss on referenced entry waits
        dir_ready = 1'b0;
        base = refill_cnt;
        expect_dir(1, 0, 3, "R9 older directive");
        send_cmd(16'h0013);
        expect_dir(1, 0, 3, "R9 refilled directive");
        send_cmd(16'h0033);
        idle(10);
        chk(refill_cnt == base, "R9 no refill while referenced", refill_cnt, base);
        chk(refill_req == 1'b0, "R9 refill_req low", int'(refill_req), 0);
        dir_ready = 1'b1;
        drain("R9 drain");
        chk(refill_cnt == base + 1, "R9 refill after release", refill_cnt, base + 1);
        chk(refill_log[$] == 16'h0033, "R9 refill addr", int'(refill_log[$]), 16'h33);

        // R6 alternation, R7 rotating scan (pointer at VP2 after serving VP1)
        dir_ready = 1'b0;
        for (int i = 0; i < 4; i++) begin
            send_cmd(16'h0025);
            expect_dir(1, 0, 5, "R6 fill");
        end
        send_cmd(16'h0025);
        send_cmd(16'h0025);
        post_tf(0, 16'h0025);
        post_tf(3, 16'h0025);
        expect_dir(0, 3, 5, "R7 vp3 served before vp0");
        expect_dir(1, 0, 5, "R6 vector after thread");
        expect_dir(0, 0, 5, "R6 thread after vector");
        expect_dir(1, 0, 5, "R6 last vector");
        idle(2);
        dir_ready = 1'b1;
        drain("R6 drain");

        // R8 hit to another entry passes an outstanding refill
        fill_lat = 20;
        base = refill_cnt;
        expect_dir(1, 0, 5, "R8 hit passes refill");
        expect_dir(1, 0, 1, "R8 first miss");
        expect_dir(1, 0, 1, "R8 second miss same entry");
        send_cmd(16'h0141);
        send_cmd(16'h0025);
        send_cmd(16'h0049);
        drain("R8 drain");
        chk(refill_cnt == base + 2, "R8 refill count", refill_cnt, base + 2);
        chk(refill_log[base] == 16'h0141, "R8 first refill addr", int'(refill_log[base]), 16'h141);
        chk(refill_log[base + 1] == 16'h0049, "R8 second refill addr", int'(refill_log[base + 1]), 16'h49);

        idle(5);
        finish_run();
    end

endmodule